// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block arbitrates eight interrupt request lines and presents one interrupt output to a processor. Software drives it through a byte-wide port that has a single address bit. Address 0 is the command port. Address 1 is the data port, which carries initialisation words and the mask.

After reset or a fresh initialisation word, the controller must receive a fixed sequence of four initialisation words before it does anything. From then on, command words control four things:
- masking;
- end-of-interrupt;
- priority rotation through a lowest-priority pointer;
- special mask mode and register readback.

The controller offers the winning request as a vector: a programmable base with the pin number in the low three bits. A processor acknowledge on `ackEn`/`ackPin` moves the request into service. A poll read does the same without the acknowledge pins.

A parameter selects whether the instance is the master. Only a master accepts special fully-nested mode. Request lines are sampled as levels every cycle. Edge capture and cascading to a second controller live outside this block.

Top module: `prio_intc`

## Requirements
- R1: A command write with bit 4 set (the start word) clears request, in-service and mask registers. It sets the lowest-priority pointer to 7, selects request-register readback, cancels poll and special mask mode, and leaves the controller not ready with `intOut` low.
- R2: The start word must have bit 1 clear and bit 0 set. Otherwise it stays not ready and data writes load the mask. With a valid start word, the next three data writes are the vector base, a cascade word (ignored) and a mode word. A mode word with bit 0 clear is refused and retried on the next data write. Once the mode word is accepted the controller is ready, later data writes load the mask, and a data-port read returns the mask.
- R3: `vecOut` is the vector base (second init word with bits 2:0 cleared) OR the pin of the winning request, or OR 7 when no request is eligible.
- R4: Priority is scanned from pin (pointer+1) mod 8 upward with wrap. A request wins if it is set and unmasked. The scan stops at the first pin already in service.
- R5: Mode word bit 1 enables automatic end-of-interrupt. Mode word bit 4 enables special fully-nested mode on a master only, in which in-service bit 2 does not block. In special mask mode no in-service bit blocks.
- R6: A command write with bits 4 and 3 clear carries these fields: bit 7 is the rotate flag (latched), bit 6 is specific, bit 5 is end-of-interrupt, and bits 2:0 are a pin. End-of-interrupt clears the in-service bit of the given pin when specific, and otherwise of the highest-priority in-service pin (skipping masked ones in special mask mode). With rotate set, the cleared pin becomes the lowest priority.
- R7: The same word with bit 5 clear and bits 7 and 6 set loads the pointer from bits 2:0.
- R8: A command write with bit 4 clear and bit 3 set: bit 6 enables an update of special mask mode to bit 5. Bit 1 enables an update of readback to bit 0 (1 = in-service, 0 = request) and of poll to bit 2. A command-port read returns the selected register.
- R9: A command-port read with poll pending clears poll. It returns 0x80 OR the pin and acknowledges that pin when one is eligible, and returns 0 otherwise.
- R10: On acknowledge, the pin's request bit clears if its line is low. With automatic end-of-interrupt, the in-service register is untouched and the pin becomes lowest priority if rotate is set. Otherwise the pin's in-service bit is set.
- R11: `intOut` is high exactly when the controller is ready and a request is eligible.
- R12: While ready, a high request line sets its request bit each cycle. While not ready, request lines are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (poll acknowledge on the following edge) |
| addr | input | 1 | 0 = command port, 1 = data port |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdEn is high, 0 otherwise |
| irqIn | input | 8 | Level request lines |
| ackEn | input | 1 | Processor acknowledge |
| ackPin | input | 3 | Pin being acknowledged |
| intOut | output | 1 | Interrupt to the processor |
| vecOut | output | 8 | Vector of the winning request |

## Verification
Priority resolution is swept over every 8-bit request pattern at each of the eight pointer positions, with a mask that changes across the sweep. This separates a correct wrap-around scan from fixed-priority or off-by-one start points. Directed sequences then set in-service bits through acknowledges and poll reads. They show that a lower request is blocked while a higher one still wins, and that special mask and fully-nested modes lift exactly the blocking they should. Specific, non-specific and rotating end-of-interrupt words are told apart by which pin wins afterwards. Refused start and mode words, and request lines driven while unready, are checked to leave no trace.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int PINS     = 8;
  localparam int PIN_W    = $clog2(PINS);
  localparam int DATA_W   = 8;
  localparam int CASC_PIN = 2;
  localparam int SPUR_PIN = PINS - 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } icwStep_t;

  // strobes and mode flags from control to datapath
  typedef struct packed {
    logic              initClr;
    logic              maskLoad;
    logic              eoiGo;
    logic              eoiSpecific;
    logic              eoiRotate;
    logic [PIN_W-1:0]  eoiPin;
    logic              prioLoad;
    logic [PIN_W-1:0]  prioVal;
    logic              ackGo;
    logic [PIN_W-1:0]  ackPin;
    logic              ready;
    logic              aeoi;
    logic              rotate;
    logic              smm;
    logic              sfn;
    logic              readIsr;
    logic              pollMode;
    logic [DATA_W-1:0] data;
  } dpCtrl_t;
endpackage

// File: rtl/prio_scan.sv
module prio_scan #(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0]         cand,
  input  logic [PINS-1:0]         stop,
  input  logic [$clog2(PINS)-1:0] lowPrio,
  output logic                    valid,
  output logic [$clog2(PINS)-1:0] pin
);
  localparam int PW = $clog2(PINS);

  always_comb begin
    logic          halted;
    logic [PW-1:0] idx;
    halted = 1'b0;
    idx    = '0;
    valid  = 1'b0;
    pin    = '0;
    for (int k = 0; k < PINS; k++) begin
      idx = PW'((int'(lowPrio) + 1 + k) % PINS);
      if (!valid && !halted) begin
        if (stop[idx]) begin
          halted = 1'b1;
        end else if (cand[idx]) begin
          valid = 1'b1;
          pin   = idx;
        end
      end
    end
  end
endmodule

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ackEn,
  input  logic [PIN_W-1:0]  ackPin,
  input  logic              eligValid,
  input  logic [PIN_W-1:0]  eligPin,
  output dpCtrl_t           strb,
  output logic              ready,
  output logic [DATA_W-1:0] vecBase
);
  icwStep_t step;
  logic aeoi, rotate, smm, sfn, readIsr, poll;

  logic cmdWr, dataWr, startHit, ocw2Hit, ocw3Hit, pollAck;

  assign cmdWr    = wrEn & ~addr;
  assign dataWr   = wrEn & addr;
  assign startHit = cmdWr & wrData[4];
  assign ocw2Hit  = cmdWr & ~wrData[4] & ~wrData[3] & ready;
  assign ocw3Hit  = cmdWr & ~wrData[4] & wrData[3] & ready;
  assign pollAck  = rdEn & ~addr & poll & eligValid;

  always_comb begin
    strb             = '0;
    strb.initClr     = startHit;
    strb.maskLoad    = dataWr & (step == ST_IDLE);
    strb.eoiGo       = ocw2Hit & wrData[5];
    strb.eoiSpecific = wrData[6];
    strb.eoiRotate   = wrData[7];
    strb.eoiPin      = wrData[PIN_W-1:0];
    strb.prioLoad    = ocw2Hit & ~wrData[5] & wrData[6] & wrData[7];
    strb.prioVal     = wrData[PIN_W-1:0];
    strb.ackGo       = pollAck | (ackEn & ready);
    strb.ackPin      = pollAck ? eligPin : ackPin;
    strb.ready       = ready;
    strb.aeoi        = aeoi;
    strb.rotate      = rotate;
    strb.smm         = smm;
    strb.sfn         = sfn;
    strb.readIsr     = readIsr;
    strb.pollMode    = poll;
    strb.data        = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step    <= ST_IDLE;
      ready   <= 1'b0;
      aeoi    <= 1'b0;
      rotate  <= 1'b0;
      smm     <= 1'b0;
      sfn     <= 1'b0;
      readIsr <= 1'b0;
      poll    <= 1'b0;
      vecBase <= '0;
    end else if (startHit) begin
      ready   <= 1'b0;
      step    <= (!wrData[1] && wrData[0]) ? ST_BASE : ST_IDLE;
      aeoi    <= 1'b0;
      rotate  <= 1'b0;
      smm     <= 1'b0;
      sfn     <= 1'b0;
      readIsr <= 1'b0;
      poll    <= 1'b0;
    end else begin
      if (dataWr) begin
        unique case (step)
          ST_BASE: begin
            vecBase <= {wrData[DATA_W-1:PIN_W], PIN_W'(0)};
            step    <= ST_CASC;
          end
          ST_CASC: step <= ST_MODE;
          ST_MODE: begin
            if (wrData[0]) begin
              aeoi  <= wrData[1];
              sfn   <= wrData[4] & IS_MASTER;
              ready <= 1'b1;
              step  <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
      if (rdEn && !addr && poll) poll <= 1'b0;
      if (ocw2Hit) rotate <= wrData[7];
      if (ocw3Hit) begin
        if (wrData[6]) smm <= wrData[5];
        if (wrData[1]) begin
          readIsr <= wrData[0];
          poll    <= wrData[2];
        end
      end
    end
  end
endmodule

// File: rtl/prio_intc_dp.sv
module prio_intc_dp
  import prio_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strb,
  input  logic [PINS-1:0]   irqIn,
  input  logic              rdEn,
  input  logic              rdAddr,
  output logic [PINS-1:0]   irr,
  output logic [PINS-1:0]   isr,
  output logic [PINS-1:0]   imr,
  output logic              eligValid,
  output logic [PIN_W-1:0]  eligPin,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [PINS-1:0] ONE = PINS'(1);

  logic [PIN_W-1:0] lowPrio;
  logic [PINS-1:0]  blocked, reqCand, isrCand, eoiHot, ackHot, capture;
  logic             isrTopValid, eoiDo, ackClr, ackSet;
  logic [PIN_W-1:0] isrTopPin, eoiTarget;

  always_comb begin
    if (strb.smm)      blocked = '0;
    else if (strb.sfn) blocked = isr & ~(ONE << CASC_PIN);
    else               blocked = isr;
  end

  assign reqCand = irr & ~imr;
  assign isrCand = strb.smm ? (isr & ~imr) : isr;

  prio_scan #(.PINS(PINS)) u_reqScan (
    .cand(reqCand), .stop(blocked), .lowPrio(lowPrio),
    .valid(eligValid), .pin(eligPin)
  );

  prio_scan #(.PINS(PINS)) u_isrScan (
    .cand(isrCand), .stop('0), .lowPrio(lowPrio),
    .valid(isrTopValid), .pin(isrTopPin)
  );

  assign eoiTarget = strb.eoiSpecific ? strb.eoiPin : isrTopPin;
  assign eoiDo     = strb.eoiGo & (strb.eoiSpecific | isrTopValid);
  assign eoiHot    = eoiDo ? (ONE << eoiTarget) : '0;
  assign ackClr    = strb.ackGo & ~irqIn[strb.ackPin];
  assign ackSet    = strb.ackGo & ~strb.aeoi;
  assign ackHot    = ONE << strb.ackPin;
  assign capture   = strb.ready ? irqIn : '0;

  always_ff @(posedge clk) begin
    if (!rstN || strb.initClr) begin
      irr     <= '0;
      isr     <= '0;
      imr     <= '0;
      lowPrio <= PIN_W'(SPUR_PIN);
    end else begin
      irr <= (irr | capture) & ~(ackClr ? ackHot : '0);
      isr <= (isr & ~eoiHot) | (ackSet ? ackHot : '0);
      if (strb.maskLoad) imr <= strb.data[PINS-1:0];
      if (strb.ackGo && strb.aeoi && strb.rotate) lowPrio <= strb.ackPin;
      else if (eoiDo && strb.eoiRotate)           lowPrio <= eoiTarget;
      else if (strb.prioLoad)                     lowPrio <= strb.prioVal;
    end
  end

  always_comb begin
    if (!rdEn)              rdData = '0;
    else if (rdAddr)        rdData = imr;
    else if (strb.pollMode) rdData = eligValid ? {1'b1, {(DATA_W-1-PIN_W){1'b0}}, eligPin} : '0;
    else if (strb.readIsr)  rdData = isr;
    else                    rdData = irr;
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [PINS-1:0]   irqIn,
  input  logic              ackEn,
  input  logic [PIN_W-1:0]  ackPin,
  output logic              intOut,
  output logic [DATA_W-1:0] vecOut
);
  dpCtrl_t           strb;
  logic              ready, eligValid;
  logic [PIN_W-1:0]  eligPin;
  logic [DATA_W-1:0] vecBase;
  logic [PINS-1:0]   irr, isr, imr;

  prio_intc_ctrl #(.IS_MASTER(IS_MASTER)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .ackEn(ackEn), .ackPin(ackPin),
    .eligValid(eligValid), .eligPin(eligPin),
    .strb(strb), .ready(ready), .vecBase(vecBase)
  );

  prio_intc_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .irqIn(irqIn),
    .rdEn(rdEn), .rdAddr(addr),
    .irr(irr), .isr(isr), .imr(imr),
    .eligValid(eligValid), .eligPin(eligPin), .rdData(rdData)
  );

  assign intOut = ready & eligValid;
  assign vecOut = vecBase | DATA_W'(eligValid ? eligPin : PIN_W'(SPUR_PIN));
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic       addr,
  input logic [7:0] wrData,
  input logic       ackEn,
  input logic       ready,
  input logic       intOut,
  input logic [7:0] vecOut,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] imr
);
  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (!intOut && irr == 8'h00 && imr == 8'h00));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && ready) |=> (imr == $past(wrData)));

  p_spur_vec_r3: assert property (@(posedge clk) disable iff (!rstN)
    !intOut |-> (vecOut[2:0] == 3'd7));

  p_spec_eoi_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && ready && wrData[6:3] == 4'b1100 && !ackEn && !rdEn)
      |=> (isr[$past(wrData[2:0])] == 1'b0));

  p_int_has_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((irr & ~imr) != 8'h00));

  p_unready_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !(wrEn && !addr && wrData[4])) |=> $stable(irr));
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .ackEn(ackEn), .ready(ready), .intOut(intOut),
  .vecOut(vecOut), .irr(irr), .isr(isr), .imr(imr)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0, ackEn = 1'b0;
  logic [7:0] wrData = '0, irqIn = '0;
  logic [2:0] ackPin = '0;
  logic [7:0] rdData, vecOut;
  logic       intOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqIn(irqIn), .ackEn(ackEn),
    .ackPin(ackPin), .intOut(intOut), .vecOut(vecOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; #1;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; rdEn = 1'b1; #1; v = rdData;
    @(negedge clk); rdEn = 1'b0; #1;
  endtask

  task automatic ack(input logic [2:0] p);
    @(negedge clk); ackEn = 1'b1; ackPin = p;
    @(negedge clk); ackEn = 1'b0; #1;
  endtask

  task automatic pulse(input logic [7:0] pat);
    @(negedge clk); irqIn = pat;
    @(negedge clk); irqIn = '0; #1;
  endtask

  task automatic init(input logic [7:0] base, input logic [7:0] mode);
    wr(1'b0, 8'h11); wr(1'b1, base); wr(1'b1, 8'h00); wr(1'b1, mode);
  endtask

  function automatic int model(input logic [7:0] req, input logic [7:0] msk,
                               input logic [7:0] svc, input int lp,
                               input bit smm, input bit sfn);
    logic [7:0] blk;
    blk = smm ? 8'h00 : (sfn ? (svc & 8'hFB) : svc);
    for (int k = 0; k < 8; k++) begin
      int p;
      p = (lp + 1 + k) % 8;
      if (blk[p]) return -1;
      if (req[p] && !msk[p]) return p;
    end
    return -1;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; fails++;
    $display("FAIL watchdog: got 0x0 expected 0x1 (run did not end)");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;

    chk("R11 reset int", intOut, 0);
    chk("R3 reset vector", vecOut, 8'h07);

    // refused start word: single mode bit set
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h55);
    rd(1'b1, v); chk("R2 bad start -> mask load", v, 8'h55);
    pulse(8'h01);
    chk("R12 unready int", intOut, 0);
    rd(1'b0, v); chk("R12 unready irr", v, 8'h00);

    init(8'h23, 8'h01);
    rd(1'b1, v); chk("R1 mask cleared", v, 8'h00);
    chk("R3 base low bits cleared", vecOut, 8'h27);
    chk("R1 int low", intOut, 0);

    pulse(8'h30);
    chk("R4 int", intOut, 1);
    chk("R4 pin4 first", vecOut, 8'h24);
    ack(3'd4);
    chk("R4 lower blocked by isr", intOut, 0);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R8 isr readback", v, 8'h10);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R10 irr cleared on ack", v, 8'h20);

    wr(1'b0, 8'h68);
    chk("R5 smm unblocks", vecOut, 8'h25);
    chk("R5 smm int", intOut, 1);
    wr(1'b0, 8'h48);
    chk("R5 smm off blocks", intOut, 0);

    pulse(8'h04);
    chk("R4 higher wins over isr", vecOut, 8'h22);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R6 nonspecific eoi", v, 8'h00);
    chk("R6 after eoi", vecOut, 8'h22);

    ack(3'd2);
    chk("R10 isr set blocks", intOut, 0);
    wr(1'b0, 8'hE2);
    rd(1'b0, v); chk("R6 specific eoi", v, 8'h00);
    chk("R6 rotate pointer", vecOut, 8'h25);
    pulse(8'h09);
    chk("R6 rotated order", vecOut, 8'h23);

    wr(1'b0, 8'hC5);
    chk("R7 set priority", vecOut, 8'h20);

    wr(1'b0, 8'h0E);
    rd(1'b0, v); chk("R9 poll read", v, 8'h80);
    rd(1'b0, v); chk("R9 poll cleared, irr", v, 8'h28);
    chk("R9 poll acked pin0", intOut, 0);
    wr(1'b0, 8'h0E);
    rd(1'b0, v); chk("R9 poll none", v, 8'h00);
    rd(1'b0, v); chk("R9 poll none cleared", v, 8'h28);

    init(8'h20, 8'h11);
    pulse(8'h04); ack(3'd2); pulse(8'h04);
    chk("R5 sfn cascade pin not self-blocked", vecOut, 8'h22);
    init(8'h20, 8'h01);
    pulse(8'h04); ack(3'd2); pulse(8'h04);
    chk("R5 no sfn blocks", intOut, 0);

    init(8'h20, 8'h03);
    wr(1'b0, 8'hC7);
    pulse(8'h03);
    chk("R10 aeoi first", vecOut, 8'h20);
    ack(3'd0);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R10 aeoi isr untouched", v, 8'h00);
    chk("R10 aeoi rotate", vecOut, 8'h21);

    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    pulse(8'h01);
    chk("R2 mode word refused", intOut, 0);
    wr(1'b1, 8'h01);
    chk("R12 ignored while unready", intOut, 0);
    pulse(8'h01);
    chk("R2 retried mode word", vecOut, 8'h20);

    for (int lp = 0; lp < 8; lp++) begin
      for (int pat = 0; pat < 256; pat++) begin
        logic [7:0] msk;
        int e;
        msk = 8'(pat * 29 + lp * 3);
        init(8'h40, 8'h01);
        wr(1'b1, msk);
        wr(1'b0, 8'hC0 | 8'(lp));
        pulse(8'(pat));
        e = model(8'(pat), msk, 8'h00, lp, 1'b0, 1'b0);
        chk("R11 sweep int", intOut, (e >= 0) ? 1 : 0);
        chk("R4 R7 sweep vector", vecOut, 8'h40 | ((e >= 0) ? e : 7));
      end
    end

    finish_run();
  end
endmodule